// File: doc/BRIEF.md
# Conditional Add/Subtract Select Unit

This block is the conditional-arithmetic slice of a 32-bit DSP-style execution stage. Every clock cycle it takes two operands, a condition word and a 3-bit operation code. It then does one of three things: a conditional add, a conditional subtract, or a two-way select. The choice between the two behaviours of each operation depends on whether the condition word is zero.

The operation result is registered. Four status bits are held next to it:
- an overflow bit,
- an "advanced" overflow bit (the top two result bits disagree),
- a sticky copy of each of those two bits.

The status bits change only when a conditional arithmetic operation actually fires. A non-firing operation writes operand A through unchanged and leaves the status bits alone. The sticky bits can only be cleared by a synchronous clear input. An optional immediate path replaces operand B with a short constant that is sign-extended by default.

Top module: `cas_select_unit`

## Requirements
- R1: While reset is asserted and after it is released, before any operation has been clocked, `res_o` is zero and all four status bits are zero.
- R2: The operation codes are: 0 = add when the condition word is nonzero, 1 = add when it is zero, 2 = subtract (A minus B) when nonzero, 3 = subtract when zero. When the operation fires, `res_o` holds the 32-bit wrapped sum or difference one clock later.
- R3: When codes 0 to 3 do not fire, `res_o` holds operand A one clock later.
- R4: On a firing add or subtract, `v_o` is set to 1 exactly when the two's-complement result does not fit in 32 bits, and to 0 otherwise.
- R5: On a firing add or subtract, `av_o` equals bit 31 XOR bit 30 of the new result.
- R6: When no add or subtract fires (non-firing codes 0 to 3, or codes 4 to 7), `v_o` and `av_o` keep their previous values.
- R7: On a firing operation, `sv_o` becomes `sv_o` OR the new `v_o`, and `sav_o` becomes `sav_o` OR the new `av_o`. Without a clear, neither sticky bit ever falls.
- R8: When `clear_sticky_i` is high, the next `sv_o` and `sav_o` equal only what that cycle's firing operation contributes, and are 0 if nothing fires.
- R9: Code 4 gives A when the condition word is nonzero and B when it is zero. Code 5 gives B when nonzero and A when zero.
- R10: When `use_imm_i` is high, operand B for every code is the 9-bit `imm_i` sign-extended to 32 bits.
- R11: Codes 6 and 7 give `res_o` = A one clock later and change no status bit apart from a requested sticky clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| clear_sticky_i | input | 1 | Clears the sticky status bits at the next edge |
| op_i | input | 3 | Operation code (see R2, R9, R11) |
| a_i | input | 32 | Operand A |
| b_i | input | 32 | Operand B |
| cond_i | input | 32 | Condition word, tested for zero |
| use_imm_i | input | 1 | Replace B with the extended immediate |
| imm_i | input | 9 | Immediate value for B |
| res_o | output | 32 | Registered result |
| v_o | output | 1 | Overflow status |
| sv_o | output | 1 | Sticky overflow status |
| av_o | output | 1 | Advanced overflow status |
| sav_o | output | 1 | Sticky advanced overflow status |

## Verification
The bench builds the unit with its defaults: a 32-bit datapath, a 9-bit immediate, and sign extension selected. Operands are drawn from a mix that is weighted toward 0x7FFFFFFF, 0x80000000, zero and all-ones, and the condition word is often forced to zero. This makes both signed overflow directions, the bit-31/bit-30 disagreement, and both polarities of every operation code common events rather than rare ones. A negative immediate exercises the sign-extension variant.

// File: rtl/cas_pkg.sv
package cas_pkg;

    typedef enum logic [2:0] {
        OP_ADD_NZ = 3'd0,
        OP_ADD_Z  = 3'd1,
        OP_SUB_NZ = 3'd2,
        OP_SUB_Z  = 3'd3,
        OP_PICK   = 3'd4,
        OP_PICKN  = 3'd5,
        OP_RSV6   = 3'd6,
        OP_RSV7   = 3'd7
    } cas_op_e;

    typedef struct packed {
        logic v;
        logic sv;
        logic av;
        logic sav;
    } cas_flags_t;

endpackage

// File: rtl/cas_cond_eval.sv
module cas_cond_eval
    import cas_pkg::*;
#(
    parameter int W = 32
) (
    input  logic [W-1:0] cond_i,
    input  cas_op_e      op_i,
    output logic         arith_o,
    output logic         sub_o,
    output logic         fire_o,
    output logic         pick_o,
    output logic         take_a_o
);

    logic cond_nz;

    assign cond_nz = |cond_i;

    always_comb begin
        arith_o  = 1'b0;
        sub_o    = 1'b0;
        fire_o   = 1'b0;
        pick_o   = 1'b0;
        take_a_o = 1'b1;
        unique case (op_i)
            OP_ADD_NZ: begin arith_o = 1'b1; fire_o = cond_nz;  end
            OP_ADD_Z:  begin arith_o = 1'b1; fire_o = !cond_nz; end
            OP_SUB_NZ: begin arith_o = 1'b1; sub_o = 1'b1; fire_o = cond_nz;  end
            OP_SUB_Z:  begin arith_o = 1'b1; sub_o = 1'b1; fire_o = !cond_nz; end
            OP_PICK:   begin pick_o = 1'b1; take_a_o = cond_nz;  end
            OP_PICKN:  begin pick_o = 1'b1; take_a_o = !cond_nz; end
            default:   begin take_a_o = 1'b1; end
        endcase
    end

endmodule

// File: rtl/cas_arith.sv
module cas_arith #(
    parameter int W = 32
) (
    input  logic [W-1:0] a_i,
    input  logic [W-1:0] b_i,
    input  logic         sub_i,
    output logic [W-1:0] sum_o,
    output logic         ovf_o,
    output logic         aovf_o
);

    logic [W-1:0] b_eff;
    logic [W-1:0] res_xor_a;
    logic [W-1:0] a_xor_b;
    logic [W-1:0] ovf_vec;

    // one adder for both directions: subtract is A + ~B + 1
    assign b_eff     = sub_i ? ~b_i : b_i;
    assign sum_o     = a_i + b_eff + {{(W-1){1'b0}}, sub_i};
    assign res_xor_a = sum_o ^ a_i;
    assign a_xor_b   = a_i ^ b_i;
    assign ovf_vec   = sub_i ? (res_xor_a & a_xor_b) : (res_xor_a & ~a_xor_b);
    assign ovf_o     = ovf_vec[W-1];
    assign aovf_o    = sum_o[W-1] ^ sum_o[W-2];

endmodule

// File: rtl/cas_imm_ext.sv
module cas_imm_ext #(
    parameter int W          = 32,
    parameter int IMM_W      = 9,
    parameter bit IMM_SIGNED = 1'b1
) (
    input  logic [IMM_W-1:0] imm_i,
    output logic [W-1:0]     ext_o
);

    localparam int PAD_W = W - IMM_W;

    generate
        if (IMM_SIGNED) begin : g_sext
            assign ext_o = {{PAD_W{imm_i[IMM_W-1]}}, imm_i};
        end else begin : g_zext
            assign ext_o = {{PAD_W{1'b0}}, imm_i};
        end
    endgenerate

endmodule

// File: rtl/cas_select_unit.sv
module cas_select_unit
    import cas_pkg::*;
#(
    parameter int W          = 32,
    parameter int IMM_W      = 9,
    parameter bit IMM_SIGNED = 1'b1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear_sticky_i,
    input  logic [2:0]       op_i,
    input  logic [W-1:0]     a_i,
    input  logic [W-1:0]     b_i,
    input  logic [W-1:0]     cond_i,
    input  logic             use_imm_i,
    input  logic [IMM_W-1:0] imm_i,
    output logic [W-1:0]     res_o,
    output logic             v_o,
    output logic             sv_o,
    output logic             av_o,
    output logic             sav_o
);

    typedef struct packed {
        logic [W-1:0] res;
        cas_flags_t   fl;
    } cas_state_t;

    cas_op_e      op_e;
    logic [W-1:0] imm_ext;
    logic [W-1:0] b_op;
    logic         is_arith;
    logic         is_sub;
    logic         fires;
    logic         is_pick;
    logic         take_a;
    logic [W-1:0] sum;
    logic         ovf;
    logic         aovf;

    cas_state_t state_d;
    cas_state_t state_q;

    assign op_e = cas_op_e'(op_i);
    assign b_op = use_imm_i ? imm_ext : b_i;

    cas_imm_ext #(
        .W          (W),
        .IMM_W      (IMM_W),
        .IMM_SIGNED (IMM_SIGNED)
    ) u_imm (
        .imm_i (imm_i),
        .ext_o (imm_ext)
    );

    cas_cond_eval #(
        .W (W)
    ) u_cond (
        .cond_i   (cond_i),
        .op_i     (op_e),
        .arith_o  (is_arith),
        .sub_o    (is_sub),
        .fire_o   (fires),
        .pick_o   (is_pick),
        .take_a_o (take_a)
    );

    cas_arith #(
        .W (W)
    ) u_arith (
        .a_i    (a_i),
        .b_i    (b_op),
        .sub_i  (is_sub),
        .sum_o  (sum),
        .ovf_o  (ovf),
        .aovf_o (aovf)
    );

    always_comb begin
        state_d        = state_q;
        state_d.res    = a_i;
        state_d.fl.sv  = clear_sticky_i ? 1'b0 : state_q.fl.sv;
        state_d.fl.sav = clear_sticky_i ? 1'b0 : state_q.fl.sav;
        if (is_arith && fires) begin
            state_d.res    = sum;
            state_d.fl.v   = ovf;
            state_d.fl.av  = aovf;
            state_d.fl.sv  = state_d.fl.sv  | ovf;
            state_d.fl.sav = state_d.fl.sav | aovf;
        end else if (is_pick) begin
            state_d.res = take_a ? a_i : b_op;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= '0;
        end else begin
            state_q <= state_d;
        end
    end

    assign res_o = state_q.res;
    assign v_o   = state_q.fl.v;
    assign sv_o  = state_q.fl.sv;
    assign av_o  = state_q.fl.av;
    assign sav_o = state_q.fl.sav;

endmodule

// File: rtl/cas_select_unit_chk.sv
module cas_select_unit_chk
    import cas_pkg::*;
#(
    parameter int W = 32
) (
    input logic         clk,
    input logic         rst_n,
    input logic         clear_sticky_i,
    input logic [2:0]   op_i,
    input logic [W-1:0] a_i,
    input logic [W-1:0] cond_i,
    input logic [W-1:0] res_o,
    input logic         v_o,
    input logic         sv_o,
    input logic         av_o,
    input logic         sav_o
);

    logic arith_fired;
    assign arith_fired = (op_i < 3'd4) && (op_i[0] ? (cond_i == '0) : (cond_i != '0));

    // R7
    sv_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sv_o && !clear_sticky_i) |=> sv_o);

    // R7
    sav_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sav_o && !clear_sticky_i) |=> sav_o);

    // R7
    sv_covers_v_chk: assert property (@(posedge clk) disable iff (!rst_n)
        arith_fired |=> (!v_o || sv_o));

    // R5
    av_bits_chk: assert property (@(posedge clk) disable iff (!rst_n)
        arith_fired |=> (av_o == (res_o[W-1] ^ res_o[W-2])));

    // R3
    add_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (op_i == OP_ADD_NZ && cond_i == '0) |=> (res_o == $past(a_i) && $stable(v_o) && $stable(av_o)));

    // R6
    pick_flags_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (op_i >= 3'd4) |=> ($stable(v_o) && $stable(av_o)));

    // R9
    pick_a_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (op_i == OP_PICK && cond_i != '0) |=> (res_o == $past(a_i)));

endmodule

bind cas_select_unit cas_select_unit_chk #(.W(W)) u_chk (.*);

// File: tb/cas_select_unit_tb.sv
`timescale 1ns/1ps
module cas_select_unit_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        clr = 1'b0;
    logic [2:0]  op = 3'd0;
    logic [31:0] a = '0, b = '0, c = '0;
    logic        use_imm = 1'b0;
    logic [8:0]  imm = '0;
    logic [31:0] res;
    logic        v, sv, av, sav;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    logic [31:0] e_res = '0;
    logic        e_v = 1'b0, e_sv = 1'b0, e_av = 1'b0, e_sav = 1'b0;

    always #4 clk = ~clk;

    cas_select_unit u_dut (
        .clk(clk), .rst_n(rst_n), .clear_sticky_i(clr), .op_i(op),
        .a_i(a), .b_i(b), .cond_i(c), .use_imm_i(use_imm), .imm_i(imm),
        .res_o(res), .v_o(v), .sv_o(sv), .av_o(av), .sav_o(sav)
    );

    task automatic check(input string req, input string what, input logic [31:0] got, input logic [31:0] exp);
        n_checks++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual=%h expected=%h", req, what, got, exp);
        end
    endtask

    function automatic logic [31:0] sext9(input logic [8:0] i);
        return {{23{i[8]}}, i};
    endfunction

    function automatic logic ovf_of(input logic [31:0] x, input logic [31:0] y, input logic s);
        longint sx, sy, ex;
        sx = longint'($signed(x));
        sy = longint'($signed(y));
        ex = s ? sx - sy : sx + sy;
        return (ex > 64'sd2147483647) || (ex < -64'sd2147483648);
    endfunction

    // drive at negedge, clock once, check at the following negedge
    task automatic apply(input logic [2:0] o, input logic [31:0] ia, input logic [31:0] ib,
                         input logic [31:0] ic, input logic ui, input logic [8:0] ii, input logic ic_clr);
        logic [31:0] bb, r;
        logic nz, fire, s, nv, nav;
        string rq_res, rq_v, rq_av, rq_st;
        op = o; a = ia; b = ib; c = ic; use_imm = ui; imm = ii; clr = ic_clr;
        bb = ui ? sext9(ii) : ib;
        nz = (ic != 0);
        fire = 1'b0; nv = 1'b0; nav = 1'b0;
        if (o < 3'd4) begin
            fire = o[0] ? !nz : nz;
            s = o[1];
            r = s ? ia - bb : ia + bb;
            if (fire) begin
                e_res = r;
                nv = ovf_of(ia, bb, s);
                nav = r[31] ^ r[30];
                e_v = nv; e_av = nav;
                rq_res = "R2";
            end else begin
                e_res = ia;
                rq_res = "R3";
            end
        end else if (o == 3'd4) begin
            e_res = nz ? ia : bb; rq_res = "R9";
        end else if (o == 3'd5) begin
            e_res = nz ? bb : ia; rq_res = "R9";
        end else begin
            e_res = ia; rq_res = "R11";
        end
        if (ui) rq_res = "R10";
        e_sv  = (ic_clr ? 1'b0 : e_sv)  | (fire & nv);
        e_sav = (ic_clr ? 1'b0 : e_sav) | (fire & nav);
        rq_v  = fire ? "R4" : "R6";
        rq_av = fire ? "R5" : "R6";
        rq_st = ic_clr ? "R8" : "R7";
        @(posedge clk);
        @(negedge clk);
        check(rq_res, "res", res, e_res);
        check(rq_v, "v", {31'd0, v}, {31'd0, e_v});
        check(rq_av, "av", {31'd0, av}, {31'd0, e_av});
        check(rq_st, "sv", {31'd0, sv}, {31'd0, e_sv});
        check(rq_st, "sav", {31'd0, sav}, {31'd0, e_sav});
    endtask

    function automatic logic [31:0] pick_val();
        case ($urandom % 7)
            0: return 32'h7FFF_FFFF;
            1: return 32'h8000_0000;
            2: return 32'h0000_0000;
            3: return 32'hFFFF_FFFF;
            4: return 32'h4000_0000;
            default: return $urandom;
        endcase
    endfunction

    initial begin
        void'($urandom(32'd5171));
        repeat (3) @(negedge clk);
        // R1: values while in reset
        check("R1", "res in reset", res, 32'd0);
        check("R1", "flags in reset", {28'd0, v, sv, av, sav}, 32'd0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1", "res after reset", res, 32'd0);
        check("R1", "flags after reset", {28'd0, v, sv, av, sav}, 32'd0);

        // R2 R4 R5: positive overflow on a firing add
        apply(3'd0, 32'h7FFF_FFFF, 32'd1, 32'd5, 1'b0, 9'd0, 1'b0);
        // R6 R9: select keeps the flags
        apply(3'd4, 32'h1111_1111, 32'h2222_2222, 32'd0, 1'b0, 9'd0, 1'b0);
        apply(3'd5, 32'h1111_1111, 32'h2222_2222, 32'd0, 1'b0, 9'd0, 1'b0);
        // R2 R4: non-overflowing subtract clears V while the sticky bits stay set (R7)
        apply(3'd3, 32'd10, 32'd3, 32'd0, 1'b0, 9'd0, 1'b0);
        // R3: add-when-zero with a nonzero condition passes A
        apply(3'd1, 32'hDEAD_BEEF, 32'd1, 32'd1, 1'b0, 9'd0, 1'b0);
        // R8: a clear with nothing firing drops both sticky bits
        apply(3'd6, 32'h0BAD_F00D, 32'd0, 32'd0, 1'b0, 9'd0, 1'b1);
        // R4: negative overflow on a subtract
        apply(3'd2, 32'h8000_0000, 32'd1, 32'd9, 1'b0, 9'd0, 1'b0);
        // R8: a clear in the same cycle as an overflowing add keeps the new event
        apply(3'd0, 32'h7FFF_FFFF, 32'h7FFF_FFFF, 32'd1, 1'b0, 9'd0, 1'b1);
        // R10: negative immediate used by both select and add
        apply(3'd4, 32'h1234_5678, 32'h0, 32'd0, 1'b1, 9'h1F0, 1'b0);
        apply(3'd0, 32'd100, 32'h0, 32'd1, 1'b1, 9'h1FF, 1'b0);
        // R11
        apply(3'd7, 32'hCAFE_0000, 32'd7, 32'd3, 1'b0, 9'd0, 1'b0);

        for (int i = 0; i < 1500; i++) begin
            logic [31:0] cv;
            cv = (($urandom % 3) == 0) ? 32'd0 : pick_val();
            apply(3'($urandom % 8), pick_val(), pick_val(), cv,
                  (($urandom % 8) == 0), 9'($urandom), (($urandom % 16) == 0));
        end

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", n_fail, n_checks);
        $finish;
    end

    initial begin
        for (int k = 0; k < 100000; k++) begin
            @(posedge clk);
            if (done) break;
        end
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("Result: errors=%0d of %0d checks", n_fail, n_checks);
            $finish;
        end
    end

endmodule